// File: doc/BRIEF.md
# Fixed-Period Fan PWM Generator

This block drives a two-wire cooling fan with one pulse-width-modulated output. Software programs it through two 32-bit registers on a simple word-addressed bus: a control word that holds a run flag, a wiring-mode flag and an 8-bit duty value, and a second word that holds a 16-bit fan speed ceiling. The period is fixed at build time. A parameter sets how many clock cycles each of the 255 duty steps lasts. At the default 100 MHz clock one period is close to 40 ms.

While running, a step counter walks from 0 to 254 and then wraps. The output is high while the step is below the programmed duty. So the duty is a fraction of 255. When the run flag is cleared, the output drops low and the period position is discarded, so the next start begins a new period. A new duty value is used straight away and is not held back to the next period boundary. The period in which the change happens can therefore mix the old and new shapes.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset, offset 0x0 reads 0x00000000, offset 0x4 reads 4000 (0x00000FA0), and pwm_out is low.
- R2: The control word sits at offset 0x0. Bit 0 is the run flag (1 = run), bit 1 is the wiring-mode flag (0 = two-wire), and bits 23:16 are the duty. A read returns these fields as last written and returns 0 in every other bit.
- R3: The speed ceiling word sits at offset 0x4 in bits 15:0. A read returns the value last written there and returns 0 in bits 31:16.
- R4: Any other address reads 0, and a write to it changes no register. This includes a misaligned address, meaning one whose two low bits are not both 0.
- R5: While running, the step counter advances once every CLKS_PER_STEP clocks through 0..254 and then returns to 0, so one period is 255*CLKS_PER_STEP clocks. pwm_out is high exactly while step < duty.
- R6: While running, a duty of 255 gives a constant high output and a duty of 0 gives a constant low output.
- R7: A write that clears the run flag makes pwm_out low from the first cycle after that write's clock edge, and pwm_out stays low while the flag is clear.
- R8: A write that sets the run flag from the stopped state starts at step 0 in the first cycle after its clock edge, wherever the previous run stopped.
- R9: A duty write while running takes effect in the first cycle after its clock edge. From then on the new duty is compared against the current step, without waiting for a period boundary.
- R10: The wiring-mode flag and the speed ceiling value have no effect on pwm_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wen | input | 1 | Write strobe; the register updates at the clock edge where this is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Fan drive, active high |

## Verification
A register write takes effect at the clock edge that samples bus_wen. Read data is combinational from bus_addr, so reading the same address on the following cycle already shows the new value. pwm_out reacts to a run, stop or duty write in the first cycle after that edge, and then steps once per CLKS_PER_STEP clocks. The bench drives on falling edges and samples at falling edges. It keeps a cycle counter that is zeroed by each starting write and advanced by every access and every sampled cycle, and it computes the expected level of every single cycle from that count.

// File: rtl/fan_pwm_pkg.sv
`timescale 1ns/1ps
package fan_pwm_pkg;
   // byte offsets of the two words; software depends on these
   localparam int unsigned CTL_OFS  = 0;
   localparam int unsigned RPM_OFS  = 4;
   // field positions inside the control word
   localparam int unsigned EN_BIT   = 0;
   localparam int unsigned MODE_BIT = 1;
   localparam int unsigned DUTY_LSB = 16;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTL,
      SEL_RPM
   } reg_sel_e;
endpackage

// File: rtl/fan_pwm_regs.sv
`timescale 1ns/1ps
module fan_pwm_regs
   import fan_pwm_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DUTY_W    = 8,
   parameter int unsigned RPM_W     = 16,
   parameter int unsigned RPM_RESET = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wen_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              run_o,
   output logic [DUTY_W-1:0] duty_o
);
   reg_sel_e          sel;
   logic              mode_q;
   logic [RPM_W-1:0]  rpm_q;
   logic              unused_wbits;

   // exact match: misaligned or foreign addresses select nothing
   always_comb begin
      if (addr_i == ADDR_W'(CTL_OFS))      sel = SEL_CTL;
      else if (addr_i == ADDR_W'(RPM_OFS)) sel = SEL_RPM;
      else                                 sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o  <= 1'b0;
         mode_q <= 1'b0;
         duty_o <= '0;
         rpm_q  <= RPM_W'(RPM_RESET);
      end else if (wen_i) begin
         case (sel)
            SEL_CTL: begin
               run_o  <= wdata_i[EN_BIT];
               mode_q <= wdata_i[MODE_BIT];
               duty_o <= wdata_i[DUTY_LSB +: DUTY_W];
            end
            SEL_RPM: rpm_q <= wdata_i[RPM_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_CTL: begin
            rdata_o[EN_BIT]               = run_o;
            rdata_o[MODE_BIT]             = mode_q;
            rdata_o[DUTY_LSB +: DUTY_W]   = duty_o;
         end
         SEL_RPM: rdata_o[RPM_W-1:0] = rpm_q;
         default: ;
      endcase
   end

   // bits outside the mapped fields are discarded on write
   assign unused_wbits = ^wdata_i;
endmodule

// File: rtl/fan_pwm_timebase.sv
`timescale 1ns/1ps
module fan_pwm_timebase #(
   parameter int unsigned CLKS_PER_STEP = 4,
   parameter int unsigned DUTY_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   output logic [DUTY_W-1:0] step_o
);
   localparam int unsigned STEPS = (1 << DUTY_W) - 1;

   logic tick;

   generate
      if (CLKS_PER_STEP == 1) begin : g_direct
         assign tick = run_i;
      end else begin : g_prescale
         localparam int unsigned PW = $clog2(CLKS_PER_STEP);
         logic [PW-1:0] pre_q;
         logic          pre_last;

         assign pre_last = (pre_q == PW'(CLKS_PER_STEP - 1));
         assign tick     = run_i && pre_last;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pre_q <= '0;
            else if (!run_i)   pre_q <= '0;
            else if (pre_last) pre_q <= '0;
            else               pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   // position is dropped whenever the generator is stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      step_o <= '0;
      else if (!run_i) step_o <= '0;
      else if (tick)   step_o <= (step_o == DUTY_W'(STEPS - 1)) ? '0 : step_o + 1'b1;
   end
endmodule

// File: rtl/fan_pwm_cmp.sv
`timescale 1ns/1ps
module fan_pwm_cmp #(
   parameter int unsigned DUTY_W = 8
) (
   input  logic              run_i,
   input  logic [DUTY_W-1:0] step_i,
   input  logic [DUTY_W-1:0] duty_i,
   output logic              pwm_o
);
   // step never reaches all-ones, so full-scale duty is a steady high
   assign pwm_o = run_i && (step_i < duty_i);
endmodule

// File: rtl/fan_pwm_ctrl.sv
`timescale 1ns/1ps
module fan_pwm_ctrl
   import fan_pwm_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DUTY_W        = 8,
   parameter int unsigned RPM_W         = 16,
   parameter int unsigned RPM_RESET     = 4000,
   parameter int unsigned CLK_HZ        = 100_000_000,
   parameter int unsigned PERIOD_MS     = 40,
   parameter int unsigned CLKS_PER_STEP = (CLK_HZ / 1000 * PERIOD_MS) / ((1 << DUTY_W) - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);
   // elaboration-time parameter checks
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x4");
      end
      if (DUTY_W < 2 || DUTY_W > 8) begin : g_bad_duty
         $error("DUTY_W must be 2..8");
      end
      if (DATA_W > 32 || DUTY_LSB + DUTY_W > DATA_W || RPM_W > DATA_W) begin : g_bad_data
         $error("fields do not fit DATA_W");
      end
      if (64'(RPM_RESET) >= (64'd1 << RPM_W)) begin : g_bad_rpm
         $error("RPM_RESET exceeds RPM_W");
      end
      if (CLKS_PER_STEP < 1) begin : g_bad_step
         $error("CLKS_PER_STEP must be at least 1");
      end
   endgenerate

   logic              ctl_en;
   logic [DUTY_W-1:0] ctl_duty;
   logic [DUTY_W-1:0] step_cnt;

   fan_pwm_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .DUTY_W   (DUTY_W),
      .RPM_W    (RPM_W),
      .RPM_RESET(RPM_RESET)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (bus_addr),
      .wen_i  (bus_wen),
      .wdata_i(bus_wdata),
      .rdata_o(bus_rdata),
      .run_o  (ctl_en),
      .duty_o (ctl_duty)
   );

   fan_pwm_timebase #(
      .CLKS_PER_STEP(CLKS_PER_STEP),
      .DUTY_W       (DUTY_W)
   ) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (ctl_en),
      .step_o(step_cnt)
   );

   fan_pwm_cmp #(
      .DUTY_W(DUTY_W)
   ) u_cmp (
      .run_i (ctl_en),
      .step_i(step_cnt),
      .duty_i(ctl_duty),
      .pwm_o (pwm_out)
   );
endmodule

// File: rtl/fan_pwm_chk.sv
`timescale 1ns/1ps
module fan_pwm_chk
   import fan_pwm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DUTY_W = 8,
   parameter int unsigned RPM_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wen,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              pwm_out,
   input logic              run,
   input logic [DUTY_W-1:0] step,
   input logic [DUTY_W-1:0] duty
);
   localparam int unsigned STEPS = (1 << DUTY_W) - 1;

   logic at_ctl, at_rpm;
   assign at_ctl = (bus_addr == ADDR_W'(CTL_OFS));
   assign at_rpm = (bus_addr == ADDR_W'(RPM_OFS));

   // R2
   ctl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_wen) && $past(at_ctl) && at_ctl) |->
      (bus_rdata[DUTY_LSB +: DUTY_W] == $past(bus_wdata[DUTY_LSB +: DUTY_W])));

   // R3
   rpm_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_wen) && $past(at_rpm) && at_rpm) |->
      (bus_rdata[RPM_W-1:0] == $past(bus_wdata[RPM_W-1:0])));

   // R4
   stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wen && !at_ctl && !at_rpm) |-> ($stable(run) && $stable(duty)));

   // R5
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step <= DUTY_W'(STEPS - 1));

   // R5
   step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (step != $past(step))) |->
      ((step == DUTY_W'($past(step) + 1'b1)) || (step == '0 && $past(step) == DUTY_W'(STEPS - 1))));

   // R6
   full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && duty == '1) |-> pwm_out);

   // R6
   zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |-> !pwm_out);

   // R7
   stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wen && at_ctl && !bus_wdata[EN_BIT]) |-> !pwm_out);

   // R8
   fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (step == '0));
endmodule

bind fan_pwm_ctrl fan_pwm_chk #(
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W),
   .DUTY_W(DUTY_W),
   .RPM_W (RPM_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wen  (bus_wen),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pwm_out  (pwm_out),
   .run      (ctl_en),
   .step     (step_cnt),
   .duty     (ctl_duty)
);

// File: tb/sim_fan_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_fan_pwm_ctrl;
   localparam int CPS   = 3;
   localparam int STEPS = 255;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic        bus_wen;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        pwm_out;

   int errors = 0;
   int checks = 0;
   int ph     = 0;   // cycles since the last starting write
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   fan_pwm_ctrl #(.CLKS_PER_STEP(CPS)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wen  (bus_wen),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pwm_out  (pwm_out)
   );

   // {requirement, address, write data, expected readback}
   localparam logic [79:0] VEC [6] = '{
      {8'd2, 8'h00, 32'hFFFF_FFFF, 32'h00FF_0003},   // R2 all ones masked
      {8'd2, 8'h00, 32'h0012_0002, 32'h0012_0002},   // R2 stopped, mode set
      {8'd3, 8'h04, 32'hABCD_1234, 32'h0000_1234},   // R3 upper half dropped
      {8'd3, 8'h04, 32'hFFFF_FFFF, 32'h0000_FFFF},   // R3
      {8'd4, 8'h08, 32'hDEAD_BEEF, 32'h0000_0000},   // R4 unmapped
      {8'd4, 8'h01, 32'hFFFF_FFFF, 32'h0000_0000}    // R4 misaligned
   };

   task automatic chk32(input string what, input int req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit restart);
      bus_addr  = a;
      bus_wdata = d;
      bus_wen   = 1'b1;
      @(negedge clk);
      bus_wen   = 1'b0;
      if (restart) ph = 0;
      else         ph++;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int req,
                     input string what);
      bus_addr = a;
      #1;
      chk32(what, req, bus_rdata, exp);
      @(negedge clk);
      ph++;
   endtask

   // expected level per cycle: high while (phase / CPS) mod 255 < duty
   task automatic wave(input int duty, input int n, input int req);
      int   bad = 0;
      int   at  = 0;
      logic a_v = 1'b0;
      logic e_v = 1'b0;
      for (int i = 0; i < n; i++) begin
         logic expv;
         expv = (((ph / CPS) % STEPS) < duty);
         if (pwm_out !== expv) begin
            if (bad == 0) begin
               at  = ph;
               a_v = pwm_out;
               e_v = expv;
            end
            bad++;
         end
         @(negedge clk);
         ph++;
      end
      checks++;
      if (bad != 0) begin
         errors++;
         $display("FAIL R%0d pwm duty=%0d at phase %0d: actual=%b expected=%b (%0d cycles off)",
                  req, duty, at, a_v, e_v, bad);
      end
   endtask

   initial begin
      rst_n     = 1'b0;
      bus_wen   = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      repeat (4) @(negedge clk);
      chk32("pwm in reset", 1, {31'd0, pwm_out}, 32'd0);              // R1
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h00, 32'h0000_0000, 1, "control after reset");            // R1
      rd(8'h04, 32'd4000, 1, "ceiling after reset");                 // R1
      chk32("pwm after reset", 1, {31'd0, pwm_out}, 32'd0);          // R1

      for (int k = 0; k < 6; k++) begin
         wr(VEC[k][71:64], VEC[k][63:32], 1'b0);
         rd(VEC[k][71:64], VEC[k][31:0], int'(VEC[k][79:72]), $sformatf("table entry %0d", k));
      end
      // R4: stray writes left both words untouched
      rd(8'h00, 32'h0012_0002, 4, "control after stray writes");
      rd(8'h04, 32'h0000_FFFF, 4, "ceiling after stray writes");
      chk32("pwm after stray writes", 4, {31'd0, pwm_out}, 32'd0);

      // R5: start with duty 10, two whole periods
      wr(8'h00, 32'h000A_0001, 1'b1);
      wave(10, 2 * STEPS * CPS, 5);

      // R10: mode flag and ceiling rewritten mid-run
      wr(8'h00, 32'h000A_0003, 1'b0);
      wr(8'h04, 32'h0000_0000, 1'b0);
      wave(10, 800, 10);
      rd(8'h00, 32'h000A_0003, 2, "control with mode flag");        // R2

      // R6: full and zero duty
      wr(8'h00, 32'h00FF_0001, 1'b0);
      wave(255, 800, 6);
      wr(8'h00, 32'h0000_0001, 1'b0);
      wave(0, 800, 6);

      // R7: stop; low at once and afterwards
      wr(8'h00, 32'h0032_0000, 1'b0);
      wave(0, 300, 7);

      // R8: restart from step 0
      wr(8'h00, 32'h0032_0001, 1'b1);
      wave(50, 60, 8);

      // R9: duty lowered then raised mid-period, applied at once
      wr(8'h00, 32'h000A_0001, 1'b0);
      wave(10, 800, 9);
      wr(8'h00, 32'h00C8_0001, 1'b0);
      wave(200, 300, 9);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule